// File: doc/BRIEF.md
# Near-Branch Direction and Target Predictor

This block supplies branch predictions to the instruction fetch front end of a processor. A direct-mapped target table is indexed by the low bits of the branch's linear address. Each entry carries a valid flag, an address tag, a branch target and a two-bit saturating direction counter. The table is written only when a branch retires, so a prediction never trains the table.

Two ports read the table. A fetch-time probe reports whether an address hits and what the table predicts for it. A decode-time port, where the branch class, displacement and any direction hint are known, produces the final prediction with a fixed priority:
- a table hit is used first;
- then a direction hint prefix;
- then the sign rule: a negative displacement is predicted taken and a non-negative one not taken.

Returns are always predicted taken, with their target taken from a circular return stack that calls fill. Far transfers pass through without a prediction.

Top module: `bp_front_predict`

## Requirements
- R1: After reset every table entry is invalid, the return stack is empty with all slots zero, and `pr_valid`, `lk_hit` and `lk_taken` are low.
- R2: A probe with `lk_valid` high reports on the next clock edge `lk_hit` (valid entry with matching tag), `lk_taken` (counter MSB on a hit) and `lk_target` (stored target on a hit, zero on a miss). The index is address bits [3:0] and the tag is the remaining upper bits.
- R3: A taken retirement (`rt_kind` 0 conditional, 1 jump, 2 call) that misses the table allocates the entry with counter value 2, which predicts taken. A not-taken retirement that hits lowers the counter by one.
- R4: The direction counter saturates at 3 and at 0 and never wraps.
- R5: A not-taken retirement that misses leaves the table unchanged.
- R6: For a conditional branch (`dc_kind` 0) with no table hit and no hint, the prediction is taken exactly when `dc_disp` is negative. The source code is 3 and the target is `dc_next + dc_disp`.
- R7: On a table miss, a hint (`dc_hint_valid`) sets the direction to `dc_hint_taken` with source code 2, overriding the sign rule. On a hit the hint is ignored.
- R8: On a table hit for a conditional branch, the direction comes from the counter MSB and the target from the entry, with source code 1. Jumps (1) and calls (2) are always predicted taken, using the entry target on a hit and otherwise `dc_next + dc_disp` with source code 3.
- R9: A call pushes `dc_next` onto the return stack. A return (`dc_kind` 3) is predicted taken from the stack top with source code 4 and pops it, so returns come back in last-in first-out order.
- R10: The return stack holds 16 entries and is circular: a push when full overwrites the oldest entry. A pop when empty raises `pr_stack_empty`, leaves the pointer in place and yields the slot it rests on.
- R11: Far transfers (`dc_kind` 4 to 7) give `pr_valid` high, not taken, source code 0 and target zero. Retiring a return or a far transfer leaves the table unchanged.
- R12: When a probe and a retirement update hit the same index in one cycle, the probe reports the contents from before the update.
- R13: Decode-time predictions never change the table; only retirement does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Fetch-time probe request |
| lk_addr | input | 32 | Linear address probed |
| lk_hit | output | 1 | Probe found a valid matching entry |
| lk_taken | output | 1 | Probe predicts taken |
| lk_target | output | 32 | Probe target (zero on miss) |
| dc_valid | input | 1 | Decoded branch present |
| dc_addr | input | 32 | Linear address of the decoded branch |
| dc_next | input | 32 | Address of the following instruction |
| dc_kind | input | 3 | Branch class: 0 cond, 1 jump, 2 call, 3 return, 4-7 far |
| dc_disp | input | 32 | Signed displacement relative to `dc_next` |
| dc_hint_valid | input | 1 | A direction hint prefix is present |
| dc_hint_taken | input | 1 | Direction given by the hint |
| pr_valid | output | 1 | Decode prediction valid |
| pr_taken | output | 1 | Predicted direction |
| pr_target | output | 32 | Predicted target |
| pr_src | output | 3 | Source: 0 none, 1 table, 2 hint, 3 sign rule, 4 return stack |
| pr_stack_empty | output | 1 | A return popped an empty stack |
| rt_valid | input | 1 | A branch retires |
| rt_addr | input | 32 | Linear address of the retiring branch |
| rt_kind | input | 3 | Class of the retiring branch, same codes |
| rt_taken | input | 1 | Resolved direction |
| rt_target | input | 32 | Resolved target |

## Verification
Every output is registered, so each probe and decode result appears exactly one clock edge after the cycle in which its request is presented. The bench drives a request, waits for that one edge, samples 1 ns later, and only then changes the inputs. A retirement affects only requests made in later cycles, never one made in the same cycle. The bench's reference model therefore computes every expectation from the table and stack contents as they stood before that cycle's updates, and applies the updates afterwards. This holds both in the directed sequences and in the seeded random phase.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [2:0] {
        BK_COND = 3'd0,
        BK_JUMP = 3'd1,
        BK_CALL = 3'd2,
        BK_RET  = 3'd3,
        BK_FAR  = 3'd4
    } br_kind_e;

    typedef enum logic [2:0] {
        PS_NONE   = 3'd0,
        PS_BUFFER = 3'd1,
        PS_HINT   = 3'd2,
        PS_STATIC = 3'd3,
        PS_STACK  = 3'd4
    } pred_src_e;

    localparam logic [1:0] CTR_ALLOC = 2'd2;

    function automatic logic [1:0] ctr_next(input logic [1:0] ctr, input logic taken);
        if (taken) return (ctr == 2'd3) ? ctr : ctr + 2'd1;
        return (ctr == 2'd0) ? ctr : ctr - 2'd1;
    endfunction

    function automatic logic trains_table(input logic [2:0] kind);
        return (kind == BK_COND) || (kind == BK_JUMP) || (kind == BK_CALL);
    endfunction

endpackage

// File: rtl/bp_btb.sv
module bp_btb
    import bp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic              ra_hit,
    output logic              ra_taken,
    output logic [ADDR_W-1:0] ra_target,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic              rb_hit,
    output logic              rb_taken,
    output logic [ADDR_W-1:0] rb_target,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_taken,
    input  logic [ADDR_W-1:0] wr_target
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ENTRIES-1:0] e_valid;
    logic [TAG_W-1:0]   e_tag [ENTRIES];
    logic [ADDR_W-1:0]  e_tgt [ENTRIES];
    logic [1:0]         e_ctr [ENTRIES];

    logic [IDX_W-1:0] ra_idx, rb_idx, wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic             wr_hit;

    assign ra_idx = ra_addr[IDX_W-1:0];
    assign rb_idx = rb_addr[IDX_W-1:0];
    assign wr_idx = wr_addr[IDX_W-1:0];
    assign wr_tag = wr_addr[ADDR_W-1:IDX_W];
    assign wr_hit = e_valid[wr_idx] && (e_tag[wr_idx] == wr_tag);

    always_comb begin
        ra_hit    = e_valid[ra_idx] && (e_tag[ra_idx] == ra_addr[ADDR_W-1:IDX_W]);
        ra_taken  = ra_hit && e_ctr[ra_idx][1];
        ra_target = ra_hit ? e_tgt[ra_idx] : '0;
        rb_hit    = e_valid[rb_idx] && (e_tag[rb_idx] == rb_addr[ADDR_W-1:IDX_W]);
        rb_taken  = rb_hit && e_ctr[rb_idx][1];
        rb_target = rb_hit ? e_tgt[rb_idx] : '0;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                e_valid[g] <= 1'b0;
                e_tag[g]   <= '0;
                e_tgt[g]   <= '0;
                e_ctr[g]   <= '0;
            end else if (wr_en && (wr_idx == MY_IDX)) begin
                if (wr_hit) begin
                    e_ctr[g] <= ctr_next(e_ctr[g], wr_taken);
                    if (wr_taken) e_tgt[g] <= wr_target;
                end else if (wr_taken) begin
                    e_valid[g] <= 1'b1;
                    e_tag[g]   <= wr_tag;
                    e_tgt[g]   <= wr_target;
                    e_ctr[g]   <= CTR_ALLOC;
                end
            end
        end
    end

endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] top_addr,
    output logic              empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  ptr;
    logic [PTR_W-1:0]  ptr_up;
    logic [CNT_W-1:0]  cnt;

    assign ptr_up   = ptr + 1'b1;
    assign top_addr = slot[ptr];
    assign empty    = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            cnt <= '0;
        end else if (push) begin
            ptr <= ptr_up;
            if (cnt != FULL) cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            ptr <= ptr - 1'b1;
            cnt <= cnt - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [PTR_W-1:0] MY_SLOT = PTR_W'(g);
        always_ff @(posedge clk) begin
            if (rst) slot[g] <= '0;
            else if (push && (ptr_up == MY_SLOT)) slot[g] <= push_addr;
        end
    end

endmodule

// File: rtl/bp_select.sv
module bp_select
    import bp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        kind,
    input  logic              hit,
    input  logic              hit_taken,
    input  logic [ADDR_W-1:0] hit_target,
    input  logic              hint_valid,
    input  logic              hint_taken,
    input  logic [ADDR_W-1:0] disp,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [ADDR_W-1:0] ras_top,
    input  logic              ras_empty,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output pred_src_e         src,
    output logic              push,
    output logic              pop,
    output logic              stack_empty
);
    logic [ADDR_W-1:0] static_tgt;
    assign static_tgt = next_addr + disp;

    always_comb begin
        taken       = 1'b0;
        target      = '0;
        src         = PS_NONE;
        push        = 1'b0;
        pop         = 1'b0;
        stack_empty = 1'b0;
        case (kind)
            BK_RET: begin
                taken       = 1'b1;
                target      = ras_top;
                src         = PS_STACK;
                pop         = 1'b1;
                stack_empty = ras_empty;
            end
            BK_JUMP, BK_CALL: begin
                push  = (kind == BK_CALL);
                taken = 1'b1;
                if (hit) begin
                    target = hit_target;
                    src    = PS_BUFFER;
                end else begin
                    target = static_tgt;
                    src    = PS_STATIC;
                end
            end
            BK_COND: begin
                if (hit) begin
                    taken  = hit_taken;
                    target = hit_target;
                    src    = PS_BUFFER;
                end else if (hint_valid) begin
                    taken  = hint_taken;
                    target = static_tgt;
                    src    = PS_HINT;
                end else begin
                    taken  = disp[ADDR_W-1];
                    target = static_tgt;
                    src    = PS_STATIC;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bp_front_predict.sv
module bp_front_predict
    import bp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ENTRIES   = 16,
    parameter int RAS_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              dc_valid,
    input  logic [ADDR_W-1:0] dc_addr,
    input  logic [ADDR_W-1:0] dc_next,
    input  logic [2:0]        dc_kind,
    input  logic [ADDR_W-1:0] dc_disp,
    input  logic              dc_hint_valid,
    input  logic              dc_hint_taken,
    output logic              pr_valid,
    output logic              pr_taken,
    output logic [ADDR_W-1:0] pr_target,
    output logic [2:0]        pr_src,
    output logic              pr_stack_empty,
    input  logic              rt_valid,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [2:0]        rt_kind,
    input  logic              rt_taken,
    input  logic [ADDR_W-1:0] rt_target
);
    logic              a_hit, a_taken, b_hit, b_taken;
    logic [ADDR_W-1:0] a_target, b_target;
    logic              tbl_wr;
    logic [ADDR_W-1:0] ras_top;
    logic              ras_empty;
    logic              s_taken, s_push, s_pop, s_empty;
    logic [ADDR_W-1:0] s_target;
    pred_src_e         s_src;

    assign tbl_wr = rt_valid && trains_table(rt_kind);

    bp_btb #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) i_btb (
        .clk      (clk),
        .rst      (rst),
        .ra_addr  (lk_addr),
        .ra_hit   (a_hit),
        .ra_taken (a_taken),
        .ra_target(a_target),
        .rb_addr  (dc_addr),
        .rb_hit   (b_hit),
        .rb_taken (b_taken),
        .rb_target(b_target),
        .wr_en    (tbl_wr),
        .wr_addr  (rt_addr),
        .wr_taken (rt_taken),
        .wr_target(rt_target)
    );

    bp_select #(.ADDR_W(ADDR_W)) i_sel (
        .kind       (dc_kind),
        .hit        (b_hit),
        .hit_taken  (b_taken),
        .hit_target (b_target),
        .hint_valid (dc_hint_valid),
        .hint_taken (dc_hint_taken),
        .disp       (dc_disp),
        .next_addr  (dc_next),
        .ras_top    (ras_top),
        .ras_empty  (ras_empty),
        .taken      (s_taken),
        .target     (s_target),
        .src        (s_src),
        .push       (s_push),
        .pop        (s_pop),
        .stack_empty(s_empty)
    );

    bp_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) i_ras (
        .clk      (clk),
        .rst      (rst),
        .push     (dc_valid && s_push),
        .push_addr(dc_next),
        .pop      (dc_valid && s_pop),
        .top_addr (ras_top),
        .empty    (ras_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_hit         <= 1'b0;
            lk_taken       <= 1'b0;
            lk_target      <= '0;
            pr_valid       <= 1'b0;
            pr_taken       <= 1'b0;
            pr_target      <= '0;
            pr_src         <= PS_NONE;
            pr_stack_empty <= 1'b0;
        end else begin
            lk_hit         <= lk_valid && a_hit;
            lk_taken       <= lk_valid && a_taken;
            lk_target      <= lk_valid ? a_target : '0;
            pr_valid       <= dc_valid;
            pr_taken       <= dc_valid && s_taken;
            pr_target      <= dc_valid ? s_target : '0;
            pr_src         <= dc_valid ? s_src : PS_NONE;
            pr_stack_empty <= dc_valid && s_empty;
        end
    end

endmodule

// File: rtl/bp_front_predict_chk.sv
module bp_front_predict_chk (
    input logic       clk,
    input logic       rst,
    input logic       lk_valid,
    input logic       lk_hit,
    input logic       lk_taken,
    input logic       dc_valid,
    input logic [2:0] dc_kind,
    input logic       dc_disp_msb,
    input logic       dc_hint_valid,
    input logic       pr_valid,
    input logic       pr_taken,
    input logic [2:0] pr_src,
    input logic       pr_stack_empty
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pr_valid && !lk_hit && !lk_taken));

    a_r2_hit_needs_probe: assert property (@(posedge clk) disable iff (rst)
        !$past(lk_valid) |-> (!lk_hit && !lk_taken));

    a_r8_pred_follows_decode: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (pr_valid == $past(dc_valid)));

    a_r11_far_passes: assert property (@(posedge clk) disable iff (rst)
        $past(dc_valid && dc_kind >= 3'd4) |-> (!pr_taken && pr_src == 3'd0));

    a_r9_return_taken: assert property (@(posedge clk) disable iff (rst)
        $past(dc_valid && dc_kind == 3'd3) |-> (pr_taken && pr_src == 3'd4));

    a_r7_hint_source: assert property (@(posedge clk) disable iff (rst)
        (pr_valid && pr_src == 3'd2) |-> $past(dc_kind == 3'd0 && dc_hint_valid));

    a_r6_sign_rule: assert property (@(posedge clk) disable iff (rst)
        (pr_valid && pr_src == 3'd3 && $past(dc_kind == 3'd0)) |-> (pr_taken == $past(dc_disp_msb)));

    a_r10_empty_on_return: assert property (@(posedge clk) disable iff (rst)
        pr_stack_empty |-> $past(dc_valid && dc_kind == 3'd3));

endmodule

bind bp_front_predict bp_front_predict_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .lk_hit        (lk_hit),
    .lk_taken      (lk_taken),
    .dc_valid      (dc_valid),
    .dc_kind       (dc_kind),
    .dc_disp_msb   (dc_disp[ADDR_W-1]),
    .dc_hint_valid (dc_hint_valid),
    .pr_valid      (pr_valid),
    .pr_taken      (pr_taken),
    .pr_src        (pr_src),
    .pr_stack_empty(pr_stack_empty)
);

// File: tb/test_bp_front_predict.sv
`timescale 1ns/1ps
module test_bp_front_predict;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 0, dc_valid = 0, dc_hint_valid = 0, dc_hint_taken = 0, rt_valid = 0, rt_taken = 0;
    logic [AW-1:0] lk_addr = 0, dc_addr = 0, dc_next = 0, dc_disp = 0, rt_addr = 0, rt_target = 0;
    logic [2:0] dc_kind = 0, rt_kind = 0;
    logic lk_hit, lk_taken, pr_valid, pr_taken, pr_stack_empty;
    logic [AW-1:0] lk_target, pr_target;
    logic [2:0] pr_src;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    bp_front_predict i_bp_front_predict (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
        .dc_valid(dc_valid), .dc_addr(dc_addr), .dc_next(dc_next), .dc_kind(dc_kind), .dc_disp(dc_disp),
        .dc_hint_valid(dc_hint_valid), .dc_hint_taken(dc_hint_taken),
        .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_target(pr_target), .pr_src(pr_src),
        .pr_stack_empty(pr_stack_empty),
        .rt_valid(rt_valid), .rt_addr(rt_addr), .rt_kind(rt_kind), .rt_taken(rt_taken), .rt_target(rt_target)
    );

    // reference model state
    logic          mv   [16];
    logic [27:0]   mtag [16];
    logic [AW-1:0] mtgt [16];
    logic [1:0]    mctr [16];
    logic [AW-1:0] mstk [16];
    int mptr, mcnt;

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        lk_valid = 0; dc_valid = 0; rt_valid = 0; dc_hint_valid = 0; dc_hint_taken = 0;
    endtask

    task automatic look(input logic [AW-1:0] a);
        lk_valid = 1; lk_addr = a;
    endtask

    task automatic dec(input logic [2:0] k, input logic [AW-1:0] a, input logic [AW-1:0] nx,
                       input logic [AW-1:0] d, input logic hv, input logic ht);
        dc_valid = 1; dc_kind = k; dc_addr = a; dc_next = nx; dc_disp = d;
        dc_hint_valid = hv; dc_hint_taken = ht;
    endtask

    task automatic retire(input logic [2:0] k, input logic [AW-1:0] a, input logic t, input logic [AW-1:0] tg);
        rt_valid = 1; rt_kind = k; rt_addr = a; rt_taken = t; rt_target = tg;
    endtask

    task automatic probe_chk(input string req, input logic [AW-1:0] a, input logic eh, input logic et,
                             input logic [AW-1:0] etg);
        look(a); tick(); idle();
        chk({req, " lk_hit"}, {31'd0, lk_hit}, {31'd0, eh});
        chk({req, " lk_taken"}, {31'd0, lk_taken}, {31'd0, et});
        chk({req, " lk_target"}, lk_target, etg);
    endtask

    task automatic pred_chk(input string req, input logic et, input logic [AW-1:0] etg,
                            input logic [2:0] es, input logic ee);
        chk({req, " pr_valid"}, {31'd0, pr_valid}, 32'd1);
        chk({req, " pr_taken"}, {31'd0, pr_taken}, {31'd0, et});
        chk({req, " pr_target"}, pr_target, etg);
        chk({req, " pr_src"}, {29'd0, pr_src}, {29'd0, es});
        chk({req, " pr_stack_empty"}, {31'd0, pr_stack_empty}, {31'd0, ee});
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            mv[i] = 0; mtag[i] = 0; mtgt[i] = 0; mctr[i] = 0; mstk[i] = 0;
        end
        mptr = 0; mcnt = 0;
    endtask

    function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
        if (t) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    task automatic random_phase(input int n);
        logic e_lh, e_lt, e_pt, e_pe;
        logic [AW-1:0] e_ltg, e_ptg;
        logic [2:0] e_ps;
        logic e_lv, e_pv;
        int li, di, ri;
        logic dh;
        for (int it = 0; it < n; it++) begin
            idle();
            e_lv = ($urandom % 2) == 1;
            e_pv = ($urandom % 2) == 1;
            if (e_lv) look(32'h0000_8000 | (($urandom % 4) << 4) | ($urandom % 16));
            if (e_pv) dec(3'($urandom % 6), 32'h0000_8000 | (($urandom % 4) << 4) | ($urandom % 16),
                          32'h0001_0000 + ($urandom % 4096), 32'($urandom % 256) - 32'd128,
                          ($urandom % 3) == 0, ($urandom % 2) == 1);
            if (($urandom % 2) == 1) begin
                logic [2:0] k;
                k = 3'($urandom % 5);
                retire(k, 32'h0000_8000 | (($urandom % 4) << 4) | ($urandom % 16),
                       (k == 3'd0) ? (($urandom % 2) == 1) : 1'b1, 32'h0002_0000 + ($urandom % 4096));
            end
            // expectations from pre-update state (R12, R13)
            li = int'(lk_addr[3:0]);
            e_lh = e_lv && mv[li] && (mtag[li] == lk_addr[31:4]);
            e_lt = e_lh && mctr[li][1];
            e_ltg = e_lh ? mtgt[li] : '0;
            di = int'(dc_addr[3:0]);
            dh = mv[di] && (mtag[di] == dc_addr[31:4]);
            e_pt = 0; e_ptg = 0; e_ps = 0; e_pe = 0;
            if (e_pv) begin
                case (dc_kind)
                    3'd3: begin
                        e_pt = 1; e_ptg = mstk[mptr]; e_ps = 4; e_pe = (mcnt == 0);
                        if (mcnt > 0) begin mptr = (mptr + 15) % 16; mcnt--; end
                    end
                    3'd1, 3'd2: begin
                        e_pt = 1;
                        e_ptg = dh ? mtgt[di] : dc_next + dc_disp;
                        e_ps = dh ? 3'd1 : 3'd3;
                        if (dc_kind == 3'd2) begin
                            mptr = (mptr + 1) % 16; mstk[mptr] = dc_next;
                            if (mcnt < 16) mcnt++;
                        end
                    end
                    3'd0: begin
                        if (dh) begin e_pt = mctr[di][1]; e_ptg = mtgt[di]; e_ps = 1; end
                        else if (dc_hint_valid) begin e_pt = dc_hint_taken; e_ptg = dc_next + dc_disp; e_ps = 2; end
                        else begin e_pt = dc_disp[31]; e_ptg = dc_next + dc_disp; e_ps = 3; end
                    end
                    default: ;
                endcase
            end
            if (rt_valid && rt_kind <= 3'd2) begin
                ri = int'(rt_addr[3:0]);
                if (mv[ri] && mtag[ri] == rt_addr[31:4]) begin
                    mctr[ri] = sat(mctr[ri], rt_taken);
                    if (rt_taken) mtgt[ri] = rt_target;
                end else if (rt_taken) begin
                    mv[ri] = 1; mtag[ri] = rt_addr[31:4]; mtgt[ri] = rt_target; mctr[ri] = 2'd2;
                end
            end
            tick();
            chk("R2 random lk_hit", {31'd0, lk_hit}, {31'd0, e_lh});
            chk("R2 random lk_taken", {31'd0, lk_taken}, {31'd0, e_lt});
            chk("R2 random lk_target", lk_target, e_ltg);
            chk("R8 random pr_valid", {31'd0, pr_valid}, {31'd0, e_pv});
            if (e_pv) begin
                chk("R8 random pr_taken", {31'd0, pr_taken}, {31'd0, e_pt});
                chk("R8 random pr_target", pr_target, e_ptg);
                chk("R8 random pr_src", {29'd0, pr_src}, {29'd0, e_ps});
                chk("R10 random pr_stack_empty", {31'd0, pr_stack_empty}, {31'd0, e_pe});
            end
        end
        idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    localparam logic [AW-1:0] A  = 32'h0000_1043;
    localparam logic [AW-1:0] B  = 32'h0000_2045;
    localparam logic [AW-1:0] F  = 32'h0000_3047;
    localparam logic [AW-1:0] T1 = 32'h0000_7700;

    initial begin
        void'($urandom(32'd1234));
        tick(); tick();
        // R1: reset state
        chk("R1 pr_valid", {31'd0, pr_valid}, 32'd0);
        chk("R1 lk_hit", {31'd0, lk_hit}, 32'd0);
        rst = 0;
        probe_chk("R1 empty table", A, 0, 0, 0);
        // R10: return on empty stack after reset
        dec(3, A, A + 2, 0, 0, 0); tick(); idle();
        pred_chk("R10 empty pop", 1, 32'd0, 3'd4, 1);

        // R6: sign rule
        dec(0, A, 32'h1045, -32'sd32, 0, 0); tick(); idle();
        pred_chk("R6 backward", 1, 32'h1025, 3'd3, 0);
        dec(0, A, 32'h1045, 32'd64, 0, 0); tick(); idle();
        pred_chk("R6 forward", 0, 32'h1085, 3'd3, 0);
        // R13: decode did not train
        probe_chk("R13 no train", A, 0, 0, 0);
        // R7: hint overrides sign rule on miss
        dec(0, A, 32'h1045, 32'd64, 1, 1); tick(); idle();
        pred_chk("R7 hint taken", 1, 32'h1085, 3'd2, 0);
        dec(0, A, 32'h1045, -32'sd32, 1, 0); tick(); idle();
        pred_chk("R7 hint not taken", 0, 32'h1025, 3'd2, 0);

        // R5: not-taken miss does not allocate
        retire(0, A, 0, T1); tick(); idle();
        probe_chk("R5 no alloc", A, 0, 0, 0);
        // R3: taken miss allocates at weakly taken
        retire(0, A, 1, T1); tick(); idle();
        probe_chk("R3 alloc", A, 1, 1, T1);
        retire(0, A, 0, T1); tick(); idle();
        probe_chk("R3 weak to not taken", A, 1, 0, T1);
        // R8 / R7: hit wins over hint
        dec(0, A, 32'h1045, -32'sd32, 1, 1); tick(); idle();
        pred_chk("R8 hit beats hint", 0, T1, 3'd1, 0);

        // R4: saturation at 3 (counter 1 -> 2 -> 3 -> 3, then one down -> 2)
        repeat (3) begin retire(0, A, 1, T1); tick(); idle(); end
        retire(0, A, 0, T1); tick(); idle();
        probe_chk("R4 saturate high", A, 1, 1, T1);
        repeat (4) begin retire(0, A, 0, T1); tick(); idle(); end
        retire(0, A, 1, T1); tick(); idle();
        probe_chk("R4 saturate low", A, 1, 0, T1);

        // R12: same-cycle probe sees old contents
        retire(1, B, 1, 32'h0000_9900); look(B); tick(); idle();
        chk("R12 old contents lk_hit", {31'd0, lk_hit}, 32'd0);
        probe_chk("R12 next cycle", B, 1, 1, 32'h0000_9900);
        // R8: jump hit uses table target
        dec(1, B, B + 2, 32'd16, 0, 0); tick(); idle();
        pred_chk("R8 jump hit", 1, 32'h0000_9900, 3'd1, 0);

        // R11: far transfers
        dec(4, F, F + 2, -32'sd8, 1, 1); tick(); idle();
        pred_chk("R11 far", 0, 32'd0, 3'd0, 0);
        retire(4, F, 1, T1); tick(); idle();
        retire(3, F, 1, T1); tick(); idle();
        probe_chk("R11 no train", F, 0, 0, 0);

        // R9: call/return LIFO
        dec(2, F, 32'h0000_4001, 32'd100, 0, 0); tick(); idle();
        pred_chk("R9 call", 1, 32'h0000_4065, 3'd3, 0);
        dec(2, F, 32'h0000_4002, 32'd100, 0, 0); tick(); idle();
        dec(3, F, F + 1, 0, 0, 0); tick(); idle();
        pred_chk("R9 ret newest", 1, 32'h0000_4002, 3'd4, 0);
        dec(3, F, F + 1, 0, 0, 0); tick(); idle();
        pred_chk("R9 ret older", 1, 32'h0000_4001, 3'd4, 0);

        // R10: overflow by one, drain, then empty pop
        for (int k = 0; k < 17; k++) begin
            dec(2, F, 32'h0000_5000 + 32'(k * 4), 0, 0, 0); tick(); idle();
        end
        for (int k = 16; k >= 1; k--) begin
            dec(3, F, F + 1, 0, 0, 0); tick(); idle();
            chk("R10 drain value", pr_target, 32'h0000_5000 + 32'(k * 4));
            chk("R10 drain not empty", {31'd0, pr_stack_empty}, 32'd0);
        end
        dec(3, F, F + 1, 0, 0, 0); tick(); idle();
        pred_chk("R10 empty after wrap", 1, 32'h0000_5040, 3'd4, 1);

        // seeded random phase from a fresh reset
        rst = 1; tick(); tick(); rst = 0;
        model_reset();
        random_phase(1500);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule